// File: doc/BRIEF.md
# Scalar Single-Precision Move Unit

This unit carries out the scalar 32-bit move between a file of 128-bit vector registers and a 32-bit data port. Each instruction arrives as a set of decoded bytes: the prefix byte, the escape byte, the opcode byte and an operand selector byte. It comes with the flags that gate vector execution. The selector decides whether the second operand is a vector register or a memory word at the supplied address. The opcode gives the direction: into the register named by the selector's reg field, or out of it.

A move between two registers replaces only the low word of the destination and keeps its upper 96 bits. A load from memory zero-fills those upper bits. A store sends out only the low word of the source. Values are copied bit for bit, with no conversion and no special handling of NaN patterns. All fault conditions are resolved in the issue cycle, before anything is written. A faulting instruction therefore leaves the register file and memory untouched. The memory side is a plain request/acknowledge handshake with an error input.

A second write port lets the surrounding pipeline update whole registers. A read port lets it inspect them.

Top module: `ssmov_unit`

## Requirements
- R1: Register-form load (prefix 0xF3, escape 0x0F, opcode 0x10, selector bits 7:6 = 2'b11): the register named by selector bits 5:3 receives bits 31:0 of the register named by bits 2:0, and keeps its bits 127:32. `done` pulses in the cycle after issue, and the new value is readable in that same cycle.
- R2: Register-form store (opcode 0x11, selector bits 7:6 = 2'b11): the register named by bits 2:0 receives bits 31:0 of the register named by bits 5:3, and keeps its bits 127:32. Timing is as in R1.
- R3: Memory-form load (opcode 0x10, selector bits 7:6 not 2'b11): a read request (`mem_we` = 0) goes out at `ins_addr`. On acknowledge, the reg-field register becomes {96'b0, `mem_rdata`} bit-exact, and `done` pulses in the cycle after the acknowledge.
- R4: Memory-form store (opcode 0x11, memory form): a write request goes out with `mem_wdata` equal to bits 31:0 of the reg-field register, captured at issue. No register changes, and `done` pulses in the cycle after the acknowledge.
- R5: Any of the following raises `flt` with `flt_code` = 1 in the cycle after issue: an emulation-trap flag set, the OS vector-enable flag clear, the vector feature flag clear, a prefix other than 0xF3, an escape other than 0x0F, or an opcode other than 0x10/0x11. A faulting instruction writes no register and makes no memory request.
- R6: With the lazy-save flag set and no R5 cause present, `flt` pulses with `flt_code` = 2 in the cycle after issue.
- R7: A memory form whose address bits 1:0 are nonzero faults with `flt_code` = 3 only when `priv_lvl` = 3 and `ctl_align_en` = 1. Otherwise the unaligned access proceeds normally.
- R8: Fault priority is code 1, then 2, then 3, then 4. Only one of `done` and `flt` is ever high.
- R9: An acknowledge with `mem_err` high ends the instruction with `flt_code` = 4, one cycle after the acknowledge. No register is written.
- R10: `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` hold steady until acknowledged. `busy` is high while a request is outstanding, and `ins_valid` is ignored while `busy` is high.
- R11: `ext_we` writes all 128 bits of entry `ext_idx`. An instruction read in the same cycle sees the old value. If an instruction writes the same entry in the same cycle, the instruction's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction offered this cycle |
| ins_prefix | input | 8 | Prefix byte |
| ins_esc | input | 8 | Escape byte |
| ins_opc | input | 8 | Opcode byte |
| ins_modrm | input | 8 | Operand selector (form 7:6, reg 5:3, rm 2:0) |
| ins_addr | input | 32 | Memory operand address |
| ctl_emul_trap | input | 1 | Emulation-trap flag (forces code 1) |
| ctl_lazy_save | input | 1 | Lazy-save flag (code 2) |
| ctl_os_vec_en | input | 1 | OS vector-state enable (clear forces code 1) |
| ctl_align_en | input | 1 | Alignment checking enabled |
| feat_vec_ok | input | 1 | Vector feature present (clear forces code 1) |
| priv_lvl | input | 2 | Current privilege level |
| busy | output | 1 | Memory transfer outstanding |
| done | output | 1 | Instruction retired |
| flt | output | 1 | Instruction faulted |
| flt_code | output | 3 | Fault code, valid with `flt` |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Load data, valid with `mem_ack` |
| mem_err | input | 1 | Memory error, valid with `mem_ack` |
| ext_we | input | 1 | External register write enable |
| ext_idx | input | 3 | External write index |
| ext_wdata | input | 128 | External write data |
| peek_idx | input | 3 | Register read index |
| peek_data | output | 128 | Register read data |

## Verification
Two writes can land on the register file in the same cycle: the external port's write and an instruction's retirement write. The bench provokes this by driving `ext_we` in the very cycle an instruction issues. It aims at the instruction's destination or at a neighbouring entry, and sometimes while that instruction still holds operands that the external write is replacing. The bench's model applies the external write after the instruction has read its operands and before the instruction's own write. It then compares every entry through the read port. An ignored-issue case overlaps a fresh `ins_valid` with an outstanding memory transfer and checks that nothing changed beyond the pending instruction's effect.

// File: rtl/ssmov_pkg.sv
package ssmov_pkg;

  localparam int VEC_W  = 128;
  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_ILLEGAL = 3'd1,
    FLT_UNAVAIL = 3'd2,
    FLT_ALIGN   = 3'd3,
    FLT_BUS     = 3'd4
  } flt_e;

  // Replace the low word, keep the upper lanes.
  function automatic logic [VEC_W-1:0] merge_low(input logic [VEC_W-1:0] keep,
                                                  input logic [WORD_W-1:0] w);
    return {keep[VEC_W-1:WORD_W], w};
  endfunction

  // Place a word in the low lane with zeroed upper lanes.
  function automatic logic [VEC_W-1:0] widen_zero(input logic [WORD_W-1:0] w);
    return {{(VEC_W-WORD_W){1'b0}}, w};
  endfunction

  // Fault resolution in priority order.
  function automatic flt_e pick_fault(input logic       enc_ok,
                                      input logic       emul,
                                      input logic       os_en,
                                      input logic       feat,
                                      input logic       lazy,
                                      input logic       mem_form,
                                      input logic [1:0] low_addr,
                                      input logic [1:0] pl,
                                      input logic       align_en);
    if (!enc_ok || emul || !os_en || !feat) return FLT_ILLEGAL;
    if (lazy) return FLT_UNAVAIL;
    if (mem_form && (low_addr != 2'b00) && (pl == 2'd3) && align_en) return FLT_ALIGN;
    return FLT_NONE;
  endfunction

endpackage

// File: rtl/ssmov_decode.sv
module ssmov_decode
  import ssmov_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic [7:0]       prefix,
  input  logic [7:0]       esc,
  input  logic [7:0]       opc,
  input  logic [7:0]       modrm,
  input  logic [1:0]       addr_lo,
  input  logic             emul,
  input  logic             lazy,
  input  logic             os_en,
  input  logic             align_en,
  input  logic             feat,
  input  logic [1:0]       pl,
  output logic             load_dir,
  output logic             mem_form,
  output logic [IDX_W-1:0] reg_f,
  output logic [IDX_W-1:0] rm_f,
  output flt_e             fault
);

  localparam logic [7:0] PFX_SCALAR = 8'hF3;
  localparam logic [7:0] ESC_TWO    = 8'h0F;
  localparam logic [7:0] OPC_LOAD   = 8'h10;
  localparam logic [7:0] OPC_STORE  = 8'h11;

  logic enc_ok;

  assign enc_ok   = (prefix == PFX_SCALAR) && (esc == ESC_TWO) &&
                    ((opc == OPC_LOAD) || (opc == OPC_STORE));
  assign load_dir = (opc == OPC_LOAD);
  assign mem_form = (modrm[7:6] != 2'b11);
  assign reg_f    = modrm[3 +: IDX_W];
  assign rm_f     = modrm[0 +: IDX_W];
  assign fault    = pick_fault(enc_ok, emul, os_en, feat, lazy, mem_form,
                               addr_lo, pl, align_en);

endmodule

// File: rtl/ssmov_regbank.sv
module ssmov_regbank #(
  parameter int NREG = 8,
  parameter int W    = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    a_we,
  input  logic [$clog2(NREG)-1:0] a_idx,
  input  logic [W-1:0]            a_data,
  input  logic                    b_we,
  input  logic [$clog2(NREG)-1:0] b_idx,
  input  logic [W-1:0]            b_data,
  input  logic [$clog2(NREG)-1:0] r0_idx,
  output logic [W-1:0]            r0_data,
  input  logic [$clog2(NREG)-1:0] r1_idx,
  output logic [W-1:0]            r1_data,
  input  logic [$clog2(NREG)-1:0] r2_idx,
  output logic [W-1:0]            r2_data
);

  localparam int IDX_W = $clog2(NREG);

  logic [W-1:0] ent_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                ent_q[i] <= '0;
      else if (a_we && (a_idx == IDX_W'(i)))     ent_q[i] <= a_data;
      else if (b_we && (b_idx == IDX_W'(i)))     ent_q[i] <= b_data;
    end
  end

  assign r0_data = ent_q[r0_idx];
  assign r1_data = ent_q[r1_idx];
  assign r2_data = ent_q[r2_idx];

  AST_PORT_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_we && b_we && (a_idx == b_idx)) |=> (ent_q[$past(a_idx)] == $past(a_data))); // R11

endmodule

// File: rtl/ssmov_unit.sv
module ssmov_unit
  import ssmov_pkg::*;
#(
  parameter int NREG   = 8,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ins_valid,
  input  logic [7:0]              ins_prefix,
  input  logic [7:0]              ins_esc,
  input  logic [7:0]              ins_opc,
  input  logic [7:0]              ins_modrm,
  input  logic [ADDR_W-1:0]       ins_addr,
  input  logic                    ctl_emul_trap,
  input  logic                    ctl_lazy_save,
  input  logic                    ctl_os_vec_en,
  input  logic                    ctl_align_en,
  input  logic                    feat_vec_ok,
  input  logic [1:0]              priv_lvl,
  output logic                    busy,
  output logic                    done,
  output logic                    flt,
  output logic [2:0]              flt_code,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [WORD_W-1:0]       mem_rdata,
  input  logic                    mem_err,
  input  logic                    ext_we,
  input  logic [$clog2(NREG)-1:0] ext_idx,
  input  logic [VEC_W-1:0]        ext_wdata,
  input  logic [$clog2(NREG)-1:0] peek_idx,
  output logic [VEC_W-1:0]        peek_data
);

  localparam int IDX_W = $clog2(NREG);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e               st_q;
  logic              done_q, flt_q;
  flt_e              code_q;
  logic              req_q, we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [IDX_W-1:0]  pend_dst_q;
  logic              pend_load_q;

  // decode
  logic             dec_load, dec_mem;
  logic [IDX_W-1:0] dec_reg, dec_rm;
  flt_e             dec_flt;

  ssmov_decode #(.IDX_W(IDX_W)) u_dec (
    .prefix   (ins_prefix),
    .esc      (ins_esc),
    .opc      (ins_opc),
    .modrm    (ins_modrm),
    .addr_lo  (ins_addr[1:0]),
    .emul     (ctl_emul_trap),
    .lazy     (ctl_lazy_save),
    .os_en    (ctl_os_vec_en),
    .align_en (ctl_align_en),
    .feat     (feat_vec_ok),
    .pl       (priv_lvl),
    .load_dir (dec_load),
    .mem_form (dec_mem),
    .reg_f    (dec_reg),
    .rm_f     (dec_rm),
    .fault    (dec_flt)
  );

  // named internal events
  logic issue, static_fault, reg_retire, mem_done, mem_load_ret;
  logic [IDX_W-1:0] src_idx, dst_idx;
  logic [VEC_W-1:0] src_val, dst_val;
  logic             inst_we;
  logic [IDX_W-1:0] inst_widx;
  logic [VEC_W-1:0] inst_wdata;

  assign issue        = ins_valid && (st_q == ST_IDLE);
  assign static_fault = (dec_flt != FLT_NONE);
  assign reg_retire   = issue && !static_fault && !dec_mem;
  assign mem_done     = (st_q == ST_WAIT) && mem_ack;
  assign mem_load_ret = mem_done && !mem_err && pend_load_q;

  assign dst_idx = dec_load ? dec_reg : dec_rm;
  assign src_idx = dec_load ? dec_rm  : dec_reg;

  always_comb begin
    inst_we    = reg_retire || mem_load_ret;
    inst_widx  = reg_retire ? dst_idx : pend_dst_q;
    inst_wdata = reg_retire ? merge_low(dst_val, src_val[WORD_W-1:0])
                            : widen_zero(mem_rdata);
  end

  ssmov_regbank #(.NREG(NREG), .W(VEC_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_we    (inst_we),
    .a_idx   (inst_widx),
    .a_data  (inst_wdata),
    .b_we    (ext_we),
    .b_idx   (ext_idx),
    .b_data  (ext_wdata),
    .r0_idx  (src_idx),
    .r0_data (src_val),
    .r1_idx  (dst_idx),
    .r1_data (dst_val),
    .r2_idx  (peek_idx),
    .r2_data (peek_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      done_q      <= 1'b0;
      flt_q       <= 1'b0;
      code_q      <= FLT_NONE;
      req_q       <= 1'b0;
      we_q        <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      pend_dst_q  <= '0;
      pend_load_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      flt_q  <= 1'b0;
      code_q <= FLT_NONE;
      if (issue) begin
        if (static_fault) begin
          flt_q  <= 1'b1;
          code_q <= dec_flt;
        end else if (!dec_mem) begin
          done_q <= 1'b1;
        end else begin
          st_q        <= ST_WAIT;
          req_q       <= 1'b1;
          we_q        <= !dec_load;
          addr_q      <= ins_addr;
          wdata_q     <= dec_load ? '0 : src_val[WORD_W-1:0];
          pend_dst_q  <= dst_idx;
          pend_load_q <= dec_load;
        end
      end else if (mem_done) begin
        st_q  <= ST_IDLE;
        req_q <= 1'b0;
        if (mem_err) begin
          flt_q  <= 1'b1;
          code_q <= FLT_BUS;
        end else begin
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = (st_q == ST_WAIT);
  assign done      = done_q;
  assign flt       = flt_q;
  assign flt_code  = code_q;
  assign mem_req   = req_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
  AST_DONE_FLT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && flt)); // R8
  AST_WRITE_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
    inst_we |=> (done && !flt)); // R1
  AST_LOAD_ZERO_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_we && busy) |-> (inst_wdata[VEC_W-1:WORD_W] == '0)); // R3
  AST_FAULT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    flt |-> !mem_req); // R5
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> busy); // R10

endmodule

// File: tb/sim_ssmov_unit.sv
`timescale 1ns/1ps
module sim_ssmov_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         ins_valid = 0;
  logic [7:0]   ins_prefix = 0, ins_esc = 0, ins_opc = 0, ins_modrm = 0;
  logic [31:0]  ins_addr = 0;
  logic         ctl_emul_trap = 0, ctl_lazy_save = 0, ctl_os_vec_en = 1, ctl_align_en = 0;
  logic         feat_vec_ok = 1;
  logic [1:0]   priv_lvl = 0;
  logic         busy, done, flt;
  logic [2:0]   flt_code;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata;
  logic         mem_ack = 0;
  logic [31:0]  mem_rdata = 0;
  logic         mem_err = 0;
  logic         ext_we = 0;
  logic [2:0]   ext_idx = 0;
  logic [127:0] ext_wdata = 0;
  logic [2:0]   peek_idx = 0;
  logic [127:0] peek_data;

  ssmov_unit u0 (.*);

  int checks = 0;
  int errors = 0;
  logic [127:0] exp_bank [8];

  int          mem_lat = 0;
  logic        err_inj = 0;
  logic [31:0] ld_word = 0;
  logic        saw_req = 0;
  logic        cap_we = 0;
  logic [31:0] cap_addr = 0, cap_wd = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] want);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, want);
    end
  endtask

  function automatic logic [2:0] want_fault(input logic [7:0] pfx, esc, opc, modrm,
                                            input logic [31:0] addr);
    bit bad = (pfx != 8'hF3) || (esc != 8'h0F) || !(opc == 8'h10 || opc == 8'h11);
    if (bad || ctl_emul_trap || !ctl_os_vec_en || !feat_vec_ok) return 3'd1;
    if (ctl_lazy_save) return 3'd2;
    if (modrm[7:6] != 2'b11 && addr[1:0] != 0 && priv_lvl == 2'd3 && ctl_align_en) return 3'd3;
    return 3'd0;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic cmp_bank(input string tag);
    bit ok = 1;
    logic [127:0] g = 0, w = 0;
    for (int i = 0; i < 8; i++) begin
      peek_idx = 3'(i);
      #0.1;
      if (ok && peek_data !== exp_bank[i]) begin
        ok = 0; g = peek_data; w = exp_bank[i];
      end
    end
    chk(ok, tag, g, w);
  endtask

  // memory responder
  initial begin
    int rcnt = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 0; mem_err = 0;
      end else if (mem_req) begin
        saw_req = 1;
        if (rcnt >= mem_lat) begin
          mem_ack = 1; mem_err = err_inj; mem_rdata = ld_word;
          cap_we = mem_we; cap_addr = mem_addr; cap_wd = mem_wdata;
          rcnt = 0;
        end else rcnt++;
      end
    end
  end

  // coll: 0 none, 1 same index as destination, 2 neighbouring index
  task automatic run_op(input logic [7:0] pfx, esc, opc, modrm, input logic [31:0] addr,
                        input int lat, input bit berr, input int coll, input bit spam);
    logic [127:0] pre [8];
    logic [2:0] fc, dst, src, cidx;
    bit memf, ld, gd, gf;
    logic [2:0] gc;
    int cyc, want_cyc;
    logic [2:0] want_code;
    bit want_done;
    for (int i = 0; i < 8; i++) pre[i] = exp_bank[i];
    fc   = want_fault(pfx, esc, opc, modrm, addr);
    memf = (modrm[7:6] != 2'b11);
    ld   = (opc == 8'h10);
    dst  = ld ? modrm[5:3] : modrm[2:0];
    src  = ld ? modrm[2:0] : modrm[5:3];
    mem_lat = lat; err_inj = berr; ld_word = $urandom;
    @(negedge clk);
    saw_req = 0;
    ins_prefix = pfx; ins_esc = esc; ins_opc = opc; ins_modrm = modrm; ins_addr = addr;
    ins_valid = 1;
    if (coll != 0) begin
      cidx = (coll == 1) ? dst : dst ^ 3'd1;
      ext_we = 1; ext_idx = cidx; ext_wdata = rnd128();
      exp_bank[cidx] = ext_wdata;   // R11: lands, operands were read before it
    end
    @(negedge clk);
    ins_valid = 0; ext_we = 0;
    cyc = 1;
    while (!(done || flt) && cyc < 40) begin
      if (spam) begin
        ins_valid = 1; ins_prefix = 8'hF3; ins_esc = 8'h0F; ins_opc = 8'h10;
        ins_modrm = 8'hC1; ins_addr = 0;
      end
      @(negedge clk);
      cyc++;
    end
    ins_valid = 0;
    gd = done; gf = flt; gc = flt_code;
    want_code = 0; want_done = 0; want_cyc = 1;
    if (fc != 0) begin
      want_code = fc;
      chk(!saw_req, "R5 no memory request on early fault", 128'(saw_req), 0);
    end else if (!memf) begin
      want_done = 1;
      exp_bank[dst] = {pre[dst][127:32], pre[src][31:0]};   // R1 / R2
    end else begin
      want_cyc = 2 + lat;
      if (berr) want_code = 3'd4;                            // R9
      else begin
        want_done = 1;
        if (ld) exp_bank[dst] = {96'b0, ld_word};            // R3
      end
      chk(cap_we == !ld && cap_addr == addr, "R3/R4 request direction and address",
          {cap_we, cap_addr}, {!ld, addr});
      if (!ld) chk(cap_wd == pre[src][31:0], "R4 store data", 128'(cap_wd), 128'(pre[src][31:0]));
    end
    chk(gd == want_done && gf == (want_code != 0) && gc == want_code,
        "R8 outcome done/flt/code", {gd, gf, gc}, {want_done, want_code != 0, want_code});
    chk(cyc == want_cyc, "R10 retire cycle", 128'(cyc), 128'(want_cyc));
    cmp_bank(spam ? "R10 bank after ignored issue" :
             (coll != 0) ? "R11 bank after collision" : "R1 bank contents");
  endtask

  task automatic flags(input bit em, ls, os, fv, al, input logic [1:0] pl);
    ctl_emul_trap = em; ctl_lazy_save = ls; ctl_os_vec_en = os; feat_vec_ok = fv;
    ctl_align_en = al; priv_lvl = pl;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL R10 watchdog got=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) exp_bank[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !flt && !mem_req, "R10 reset outputs idle",
        {busy, done, flt, mem_req}, 0);
    cmp_bank("R11 reset bank zero");

    // preload through the external port
    for (int i = 0; i < 8; i++) begin
      ext_we = 1; ext_idx = 3'(i); ext_wdata = rnd128(); exp_bank[i] = ext_wdata;
      @(negedge clk);
    end
    ext_we = 0;
    cmp_bank("R11 external writes land");

    flags(0, 0, 1, 1, 1, 2'd3);
    run_op(8'hF3, 8'h0F, 8'h10, 8'hD3, 0, 0, 0, 0, 0);      // R1 load reg form 2 <- 3
    run_op(8'hF3, 8'h0F, 8'h11, 8'hE8, 0, 0, 0, 0, 0);      // R2 store reg form 0 <- 5
    run_op(8'hF3, 8'h0F, 8'h10, 8'h08, 32'h100, 0, 0, 0, 0); // R3 load lat 0
    ld_word = 32'h7FC00001;
    run_op(8'hF3, 8'h0F, 8'h10, 8'h48, 32'h204, 3, 0, 0, 0); // R3 lat 3
    run_op(8'hF3, 8'h0F, 8'h11, 8'h38, 32'h30, 2, 0, 0, 0);  // R4 store
    // R5 causes
    flags(1, 0, 1, 1, 0, 0); run_op(8'hF3, 8'h0F, 8'h10, 8'hC1, 0, 0, 0, 0, 0);
    flags(0, 0, 0, 1, 0, 0); run_op(8'hF3, 8'h0F, 8'h10, 8'h00, 0, 0, 0, 0, 0);
    flags(0, 0, 1, 0, 0, 0); run_op(8'hF3, 8'h0F, 8'h11, 8'hC1, 0, 0, 0, 0, 0);
    flags(0, 0, 1, 1, 0, 0); run_op(8'h66, 8'h0F, 8'h10, 8'hC1, 0, 0, 0, 0, 0);
    run_op(8'hF3, 8'h0F, 8'h12, 8'hC1, 0, 0, 0, 0, 0);
    // R6
    flags(0, 1, 1, 1, 0, 0); run_op(8'hF3, 8'h0F, 8'h10, 8'h00, 0, 0, 0, 0, 0);
    // R7 alignment variants
    flags(0, 0, 1, 1, 1, 2'd3); run_op(8'hF3, 8'h0F, 8'h10, 8'h10, 32'h102, 0, 0, 0, 0);
    flags(0, 0, 1, 1, 1, 2'd0); run_op(8'hF3, 8'h0F, 8'h10, 8'h10, 32'h103, 1, 0, 0, 0);
    flags(0, 0, 1, 1, 0, 2'd3); run_op(8'hF3, 8'h0F, 8'h11, 8'h10, 32'h101, 0, 0, 0, 0);
    // R8 priority
    flags(1, 1, 1, 1, 1, 2'd3); run_op(8'hF3, 8'h0F, 8'h10, 8'h10, 32'h1, 0, 1, 0, 0);
    flags(0, 1, 1, 1, 1, 2'd3); run_op(8'hF3, 8'h0F, 8'h10, 8'h10, 32'h1, 0, 1, 0, 0);
    flags(0, 0, 1, 1, 1, 2'd3); run_op(8'hF3, 8'h0F, 8'h10, 8'h10, 32'h1, 0, 1, 0, 0);
    // R9 bus errors
    flags(0, 0, 1, 1, 0, 0);
    run_op(8'hF3, 8'h0F, 8'h10, 8'h20, 32'h40, 2, 1, 0, 0);
    run_op(8'hF3, 8'h0F, 8'h11, 8'h20, 32'h44, 0, 1, 0, 0);
    // R10 ignored issue while busy
    run_op(8'hF3, 8'h0F, 8'h10, 8'h18, 32'h80, 3, 0, 0, 1);
    // R11 collisions
    run_op(8'hF3, 8'h0F, 8'h10, 8'hE2, 0, 0, 0, 1, 0);
    run_op(8'hF3, 8'h0F, 8'h11, 8'hE2, 0, 0, 0, 2, 0);
    run_op(8'hF3, 8'h0F, 8'h10, 8'hC9, 0, 0, 0, 1, 0);
    run_op(8'hF3, 8'h0F, 8'h10, 8'h28, 32'h8, 1, 0, 1, 0);

    for (int n = 0; n < 300; n++) begin
      logic [7:0] pf, es, oc, mr;
      logic [31:0] ad;
      pf = ($urandom % 12 == 0) ? 8'($urandom) : 8'hF3;
      es = ($urandom % 12 == 0) ? 8'($urandom) : 8'h0F;
      oc = ($urandom % 10 == 0) ? 8'($urandom) : (($urandom % 2) ? 8'h10 : 8'h11);
      mr = 8'($urandom);
      ad = {$urandom} & 32'hFFFF_FFFC;
      if ($urandom % 4 == 0) ad[1:0] = 2'($urandom);
      flags($urandom % 8 == 0, $urandom % 8 == 0, $urandom % 8 != 0, $urandom % 8 != 0,
            1'($urandom), 2'($urandom));
      run_op(pf, es, oc, mr, ad, $urandom % 4, $urandom % 10 == 0,
             ($urandom % 6 == 0) ? int'(1 + $urandom % 2) : 0, $urandom % 8 == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule